// File: doc/BRIEF.md
# Instruction-Driven Register Datapath

This block is a 16-bit datapath that carries out one instruction on every rising clock edge. The instruction comes from outside the block, so there is no program counter and no fetch logic. Each instruction is a 16-bit word. When an operation needs a constant, the 16-bit constant is presented on a separate input in the same cycle. The block splits the word into an opcode and three register selectors. It reads up to three of its eight 16-bit registers. It then computes a logic, arithmetic or shift result, or reads or writes a small word-addressed data memory, and writes the result into the destination register at the clock edge.

Every register is visible on one flat output bus, so a test harness or a higher-level controller can watch the architectural state directly. Two sticky flags report a halt or a trap. After either flag is set, the datapath ignores all further instructions until reset. Compare and branch opcodes are recognised and do nothing, because control flow belongs to whatever drives the instruction input.

Top module: `instr_datapath`

## Requirements
- R1: Instruction fields are: opcode in bits [5:0], destination register L in bits [8:6], first source A in bits [11:9], second source B in bits [14:12]. Bit 15 has no effect.
- R2: Register-operand logic opcodes write into L: 1 gives A, 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 gives NOT A.
- R3: Opcode 6 writes A+B, opcode 7 writes A−B, and opcode 8 writes 0−A into L. All are modulo 2^16.
- R4: Opcodes 9, 10 and 11 shift A left logically, right logically, and right arithmetically by the full 16-bit value of B. An amount of 16 or more gives 0 for the logical shifts and 16 copies of A's sign bit for the arithmetic shift.
- R5: Immediate forms use the immediate input as the second operand. Opcode 26 writes the immediate into L. Opcodes 27/28/29 give AND/OR/XOR. Opcodes 30/31 give add/subtract (A − imm). Opcodes 32/33/34 give left/right/arithmetic-right shifts, with the shift rule of R4.
- R6: Opcode 12 loads into L the memory word addressed by register A. Opcode 13 stores register A into the word addressed by register L. The address is the low log2(depth) bits of the register value, so with the default depth of 256, the values 0x0105 and 0x0005 name the same word.
- R7: Opcode 0 and opcodes 14–25 and 35–46 leave every register unchanged.
- R8: Opcode 63 and opcodes 47–61 set the halt flag and change no register. The flag stays set until reset, and no later instruction changes a register or memory.
- R9: Opcode 62 sets the trap flag and changes no register. The flag stays set until reset, and no later instruction has any effect.
- R10: A synchronous active-high reset clears all eight registers and both flags one edge later. Memory contents are not cleared.
- R11: The result of an instruction is visible on the register output after exactly one clock edge, and the next instruction can use it as a source in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction to execute at the next edge |
| imm_word | input | 16 | Immediate operand, used only by opcodes 26–34 |
| reg_bank | output | 128 | All registers, register n in bits [16n+15:16n] |
| halted | output | 1 | Sticky halt flag |
| trapped | output | 1 | Sticky trap flag |

## Verification
All architectural state is on the ports, so a wrong register write appears on the bus at the first falling edge after the edge that made it. A decode error that writes the wrong destination or skips a write also shows up in that cycle. Corruption inside the data memory stays hidden until a load reads the bad word, so every store is followed by loads, including a load through an aliased address. A flag that fails to stick, or an instruction that runs after a stop, changes the flags or registers one cycle after the stop.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int OPW = 6;
  localparam int SELW = 3;

  localparam logic [OPW-1:0] OP_MOV_R   = 6'd1;
  localparam logic [OPW-1:0] OP_AND_R   = 6'd2;
  localparam logic [OPW-1:0] OP_IOR_R   = 6'd3;
  localparam logic [OPW-1:0] OP_XOR_R   = 6'd4;
  localparam logic [OPW-1:0] OP_NOT_R   = 6'd5;
  localparam logic [OPW-1:0] OP_ADD_R   = 6'd6;
  localparam logic [OPW-1:0] OP_SUB_R   = 6'd7;
  localparam logic [OPW-1:0] OP_NEG_R   = 6'd8;
  localparam logic [OPW-1:0] OP_SHL_R   = 6'd9;
  localparam logic [OPW-1:0] OP_SHR_R   = 6'd10;
  localparam logic [OPW-1:0] OP_SAR_R   = 6'd11;
  localparam logic [OPW-1:0] OP_LOAD    = 6'd12;
  localparam logic [OPW-1:0] OP_STORE   = 6'd13;
  localparam logic [OPW-1:0] OP_MOV_I   = 6'd26;
  localparam logic [OPW-1:0] OP_AND_I   = 6'd27;
  localparam logic [OPW-1:0] OP_IOR_I   = 6'd28;
  localparam logic [OPW-1:0] OP_XOR_I   = 6'd29;
  localparam logic [OPW-1:0] OP_ADD_I   = 6'd30;
  localparam logic [OPW-1:0] OP_SUB_I   = 6'd31;
  localparam logic [OPW-1:0] OP_SHL_I   = 6'd32;
  localparam logic [OPW-1:0] OP_SHR_I   = 6'd33;
  localparam logic [OPW-1:0] OP_SAR_I   = 6'd34;
  localparam logic [OPW-1:0] OP_HALT_LO = 6'd47;
  localparam logic [OPW-1:0] OP_TRAP    = 6'd62;

  typedef enum logic [3:0] {
    ALU_PASS_A, ALU_PASS_B, ALU_AND, ALU_IOR, ALU_XOR, ALU_NOT,
    ALU_ADD, ALU_SUB, ALU_NEG, ALU_SHL, ALU_SHR, ALU_SAR
  } alu_op_e;

  typedef struct packed {
    alu_op_e         fn;
    logic            use_imm;
    logic            wr_en;
    logic            is_load;
    logic            is_store;
    logic            halt;
    logic            trap;
    logic [SELW-1:0] sel_l;
    logic [SELW-1:0] sel_a;
    logic [SELW-1:0] sel_b;
  } ctrl_t;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_pkg::*;
(
  input  logic [15:0] word,
  output ctrl_t       ctrl
);
  logic [OPW-1:0] op;
  logic           unused_spare;

  assign op = word[OPW-1:0];
  assign unused_spare = word[15];

  always_comb begin
    ctrl          = '0;
    ctrl.fn       = ALU_PASS_A;
    ctrl.sel_l    = word[8:6];
    ctrl.sel_a    = word[11:9];
    ctrl.sel_b    = word[14:12];
    ctrl.wr_en    = 1'b1;
    case (op)
      OP_MOV_R: ctrl.fn = ALU_PASS_A;
      OP_AND_R: ctrl.fn = ALU_AND;
      OP_IOR_R: ctrl.fn = ALU_IOR;
      OP_XOR_R: ctrl.fn = ALU_XOR;
      OP_NOT_R: ctrl.fn = ALU_NOT;
      OP_ADD_R: ctrl.fn = ALU_ADD;
      OP_SUB_R: ctrl.fn = ALU_SUB;
      OP_NEG_R: ctrl.fn = ALU_NEG;
      OP_SHL_R: ctrl.fn = ALU_SHL;
      OP_SHR_R: ctrl.fn = ALU_SHR;
      OP_SAR_R: ctrl.fn = ALU_SAR;
      OP_LOAD:  ctrl.is_load = 1'b1;
      OP_STORE: begin ctrl.is_store = 1'b1; ctrl.wr_en = 1'b0; end
      OP_MOV_I: begin ctrl.fn = ALU_PASS_B; ctrl.use_imm = 1'b1; end
      OP_AND_I: begin ctrl.fn = ALU_AND;    ctrl.use_imm = 1'b1; end
      OP_IOR_I: begin ctrl.fn = ALU_IOR;    ctrl.use_imm = 1'b1; end
      OP_XOR_I: begin ctrl.fn = ALU_XOR;    ctrl.use_imm = 1'b1; end
      OP_ADD_I: begin ctrl.fn = ALU_ADD;    ctrl.use_imm = 1'b1; end
      OP_SUB_I: begin ctrl.fn = ALU_SUB;    ctrl.use_imm = 1'b1; end
      OP_SHL_I: begin ctrl.fn = ALU_SHL;    ctrl.use_imm = 1'b1; end
      OP_SHR_I: begin ctrl.fn = ALU_SHR;    ctrl.use_imm = 1'b1; end
      OP_SAR_I: begin ctrl.fn = ALU_SAR;    ctrl.use_imm = 1'b1; end
      default: begin
        // no-op, compare/branch placeholders, trap and halt: no write
        ctrl.wr_en = 1'b0;
        if (op == OP_TRAP)          ctrl.trap = 1'b1;
        else if (op >= OP_HALT_LO)  ctrl.halt = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      fn,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res
);
  localparam int SW = $clog2(W);

  logic          too_far;
  logic [SW-1:0] amt;

  assign too_far = |y[W-1:SW];
  assign amt     = y[SW-1:0];

  always_comb begin
    case (fn)
      ALU_PASS_A: res = x;
      ALU_PASS_B: res = y;
      ALU_AND:    res = x & y;
      ALU_IOR:    res = x | y;
      ALU_XOR:    res = x ^ y;
      ALU_NOT:    res = ~x;
      ALU_ADD:    res = x + y;
      ALU_SUB:    res = x - y;
      ALU_NEG:    res = '0 - x;
      ALU_SHL:    res = too_far ? '0 : (x << amt);
      ALU_SHR:    res = too_far ? '0 : (x >> amt);
      ALU_SAR:    res = too_far ? {W{x[W-1]}} : W'($signed(x) >>> amt);
      default:    res = x;
    endcase
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SW-1:0]   wsel,
  input  logic [W-1:0]    wdata,
  input  logic [SW-1:0]   rsel_a,
  input  logic [SW-1:0]   rsel_b,
  input  logic [SW-1:0]   rsel_l,
  output logic [W-1:0]    rd_a,
  output logic [W-1:0]    rd_b,
  output logic [W-1:0]    rd_l,
  output logic [NREG*W-1:0] flat
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wsel] <= wdata;
    end
  end

  assign rd_a = regs[rsel_a];
  assign rd_b = regs[rsel_b];
  assign rd_l = regs[rsel_l];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat[g*W +: W] = regs[g];
  end

  // R7: with no write enable the whole bank holds
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat));
  // R11: the written value is in the bank one edge later
  a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(wsel)] == $past(wdata));
endmodule

// File: rtl/dp_dmem.sv
module dp_dmem #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/instr_datapath.sv
module instr_datapath
  import dp_pkg::*;
#(
  parameter int W     = 16,
  parameter int NREG  = 8,
  parameter int DEPTH = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     instr_word,
  input  logic [W-1:0]    imm_word,
  output logic [NREG*W-1:0] reg_bank,
  output logic            halted,
  output logic            trapped
);
  localparam int AW = $clog2(DEPTH);

  ctrl_t        ctrl;
  logic         running;
  logic [W-1:0] val_a, val_b, val_l, operand2, alu_res, mem_rd, wr_val;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  addr_src;
  logic          unused_addr_hi;

  dp_decode u_dec (.word(instr_word), .ctrl(ctrl));

  assign running  = !halted && !trapped;
  assign operand2 = ctrl.use_imm ? imm_word : val_b;

  dp_alu #(.W(W)) u_alu (.fn(ctrl.fn), .x(val_a), .y(operand2), .res(alu_res));

  assign addr_src       = ctrl.is_store ? val_l : val_a;
  assign mem_addr       = addr_src[AW-1:0];
  assign unused_addr_hi = ^addr_src;

  dp_dmem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(running && ctrl.is_store), .addr(mem_addr),
    .wdata(val_a), .rdata(mem_rd)
  );

  assign wr_val = ctrl.is_load ? mem_rd : alu_res;

  dp_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(running && ctrl.wr_en),
    .wsel(ctrl.sel_l[$clog2(NREG)-1:0]), .wdata(wr_val),
    .rsel_a(ctrl.sel_a[$clog2(NREG)-1:0]), .rsel_b(ctrl.sel_b[$clog2(NREG)-1:0]),
    .rsel_l(ctrl.sel_l[$clog2(NREG)-1:0]),
    .rd_a(val_a), .rd_b(val_b), .rd_l(val_l), .flat(reg_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted  <= 1'b0;
      trapped <= 1'b0;
    end else if (running) begin
      if (ctrl.halt) halted  <= 1'b1;
      if (ctrl.trap) trapped <= 1'b1;
    end
  end

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r9_trap_sticky: assert property (@(posedge clk) disable iff (rst)
    trapped |=> trapped);
  a_r8_single_stop_cause: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halted, trapped}));
  a_r9_frozen_after_stop: assert property (@(posedge clk) disable iff (rst)
    (halted || trapped) |=> $stable(reg_bank));
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (reg_bank == '0 && !halted && !trapped));
endmodule

// File: tb/instr_datapath_bench.sv
module instr_datapath_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  instr_word = 16'h0000;
  logic [15:0]  imm_word = 16'h0000;
  logic [127:0] reg_bank;
  logic         halted, trapped;

  int tests_run = 0;
  int tests_failed = 0;

  logic [15:0] m_reg [8];
  logic [15:0] m_mem [DEPTH];
  logic        m_halt, m_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_datapath u_instr_datapath (
    .clk(clk), .rst(rst), .instr_word(instr_word), .imm_word(imm_word),
    .reg_bank(reg_bank), .halted(halted), .trapped(trapped)
  );

  function automatic logic [15:0] shift_ref(input int kind, input logic [15:0] v, input logic [15:0] n);
    int k = n;
    logic [15:0] r = v;
    if (k >= 16) begin
      if (kind == 2) return {16{v[15]}};
      return 16'h0000;
    end
    for (int i = 0; i < k; i++) begin
      if (kind == 0)      r = {r[14:0], 1'b0};
      else if (kind == 1) r = {1'b0, r[15:1]};
      else                r = {r[15], r[15:1]};
    end
    return r;
  endfunction

  task automatic model_step(input logic [15:0] w, input logic [15:0] im);
    int op = w[5:0];
    int l = w[8:6];
    int a = w[11:9];
    int b = w[14:12];
    logic [15:0] va = m_reg[a];
    logic [15:0] vb = m_reg[b];
    if (m_halt || m_trap) return;
    case (op)
      1:  m_reg[l] = va;
      2:  m_reg[l] = va & vb;
      3:  m_reg[l] = va | vb;
      4:  m_reg[l] = va ^ vb;
      5:  m_reg[l] = ~va;
      6:  m_reg[l] = va + vb;
      7:  m_reg[l] = va - vb;
      8:  m_reg[l] = 16'h0000 - va;
      9:  m_reg[l] = shift_ref(0, va, vb);
      10: m_reg[l] = shift_ref(1, va, vb);
      11: m_reg[l] = shift_ref(2, va, vb);
      12: m_reg[l] = m_mem[va % DEPTH];
      13: m_mem[m_reg[l] % DEPTH] = va;
      26: m_reg[l] = im;
      27: m_reg[l] = va & im;
      28: m_reg[l] = va | im;
      29: m_reg[l] = va ^ im;
      30: m_reg[l] = va + im;
      31: m_reg[l] = va - im;
      32: m_reg[l] = shift_ref(0, va, im);
      33: m_reg[l] = shift_ref(1, va, im);
      34: m_reg[l] = shift_ref(2, va, im);
      62: m_trap = 1'b1;
      default: if (op >= 47) m_halt = 1'b1;
    endcase
  endtask

  task automatic compare(input string tag);
    string why = "";
    tests_run++;
    for (int i = 0; i < 8; i++)
      if (why == "" && reg_bank[i*16 +: 16] !== m_reg[i])
        why = $sformatf("reg%0d actual=%h expected=%h", i, reg_bank[i*16 +: 16], m_reg[i]);
    if (why == "" && (halted !== m_halt || trapped !== m_trap))
      why = $sformatf("flags actual=%b%b expected=%b%b", halted, trapped, m_halt, m_trap);
    if (why != "") begin
      tests_failed++;
      $display("FAIL %s %s", tag, why);
    end
  endtask

  // entered and left at a falling edge
  task automatic apply(input logic [15:0] w, input logic [15:0] im, input string tag);
    instr_word = w;
    imm_word = im;
    @(posedge clk);
    model_step(w, im);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0000;
    m_halt = 1'b0;
    m_trap = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    compare("R10");
  endtask

  function automatic logic [15:0] enc(input int op, input int l, input int a, input int b);
    return {1'b0, 3'(b), 3'(a), 3'(l), 6'(op)};
  endfunction

  function automatic string tag_of(input int op);
    if (op >= 1 && op <= 5) return "R2";
    if (op >= 6 && op <= 8) return "R3";
    if (op >= 9 && op <= 11) return "R4";
    if (op >= 26 && op <= 34) return "R5";
    return "R7";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R5, R11: immediate moves, including 12345 into register 5
    for (int i = 0; i < 8; i++)
      apply(enc(26, i, 0, 0), 16'(i * 16'h1111 + 3), "R5");
    apply(enc(26, 5, 0, 0), 16'd12345, "R11");
    apply(enc(6, 4, 5, 5), 16'h0000, "R11");

    // R1: fixed words and the spare top bit
    apply(16'h3107, 16'h0000, "R1");
    apply(16'h6BCA, 16'h0000, "R1");
    apply(16'hB107, 16'h0000, "R1");
    apply(16'hEBCA, 16'hFFFF, "R1");

    // R4: shift amount limits
    apply(enc(26, 6, 0, 0), 16'd16, "R4");
    apply(enc(26, 1, 0, 0), 16'h8421, "R4");
    apply(enc(9, 2, 1, 6), 16'h0000, "R4");
    apply(enc(11, 3, 1, 6), 16'h0000, "R4");
    apply(enc(34, 3, 1, 0), 16'd15, "R4");
    apply(enc(33, 3, 1, 0), 16'hFFFF, "R4");
    apply(enc(34, 3, 1, 0), 16'h0100, "R4");
    apply(enc(32, 3, 1, 0), 16'd0, "R4");

    // mixed operations
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [15:0] im;
      op = $urandom_range(0, 46);
      if (op == 12 || op == 13) op = 1;
      im = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 20)) : 16'($urandom);
      apply({1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 6'(op)}, im, tag_of(op));
    end

    // R6: store then load, with an aliased address
    apply(enc(26, 1, 0, 0), 16'h0005, "R6");
    apply(enc(26, 2, 0, 0), 16'hBEEF, "R6");
    apply(enc(13, 1, 2, 0), 16'h0000, "R6");
    apply(enc(26, 3, 0, 0), 16'h0105, "R6");
    apply(enc(12, 4, 3, 0), 16'h0000, "R6");
    apply(enc(26, 2, 0, 0), 16'h1234, "R6");
    apply(enc(26, 1, 0, 0), 16'h00FF, "R6");
    apply(enc(13, 1, 2, 0), 16'h0000, "R6");
    apply(enc(12, 7, 1, 0), 16'h0000, "R6");
    apply(enc(12, 6, 3, 0), 16'h0000, "R6");

    // R9: trap sticks and freezes state
    apply(enc(62, 0, 0, 0), 16'h0000, "R9");
    apply(enc(26, 0, 0, 0), 16'hAAAA, "R9");
    apply(enc(13, 1, 0, 0), 16'h0000, "R9");
    apply(enc(63, 0, 0, 0), 16'h0000, "R9");
    do_reset();
    // memory survives reset (R10); the freeze kept the store out (R9)
    apply(enc(26, 1, 0, 0), 16'h00FF, "R10");
    apply(enc(12, 2, 1, 0), 16'h0000, "R9");

    // R8: halt on an unassigned code and on 63
    apply(enc(26, 3, 0, 0), 16'h7777, "R8");
    apply(enc(50, 3, 3, 3), 16'h0000, "R8");
    apply(enc(26, 3, 0, 0), 16'h1111, "R8");
    apply(enc(62, 0, 0, 0), 16'h0000, "R8");
    do_reset();
    apply(enc(63, 0, 0, 0), 16'h0000, "R8");
    apply(enc(6, 1, 1, 1), 16'h0000, "R8");
    do_reset();
    apply(enc(47, 0, 0, 0), 16'h0000, "R8");
    do_reset();
    apply(enc(0, 5, 0, 0), 16'h5555, "R7");

    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule